// File: doc/BRIEF.md
# Codec Control-Word Serial Writer

This block writes one register of an audio codec over a three-wire serial control path. The host presents a single-cycle request that names the target codec (0 or 1), a 5-bit register index and an 8-bit data byte. The block builds a 16-bit control word and shifts it out on a clock/data pair. The word is framed by the active-low select of the addressed codec. A request that names a codec that does not exist is dropped, and the serial pins do not move.

The serial clock is derived from the system clock. A divider input gives the length of each half period in system clock cycles. The block samples this input when it accepts a request. `busy` covers the whole transfer. `done` marks its end with a single-cycle pulse.

Top module: `cw_writer`

## Requirements
- R1: The control word is {2'b10, 1'b1, reg[4:0], data[7:0]}. Bits 15:14 hold the fixed codec address 2'b10, bit 13 is the write flag 1, bits 12:8 hold the register index and bits 7:0 hold the data byte.
- R2: The word leaves most significant bit first, bit 15 down to bit 0. Each frame has exactly 16 rising edges of `sclk`, and `sdata` is valid at each rising edge.
- R3: While a select is low, `sdata` changes only when `sclk` is low. It changes in the same cycle that `sclk` falls.
- R4: `csN[0]` belongs to codec 0 and `csN[1]` to codec 1. Only the addressed select goes low, it stays low for the whole frame, and the two are never low together.
- R5: A request with `reqCodec` of 2 or more is ignored. `busy` stays low, no `done` pulse appears, and `csN`, `sclk` and `sdata` stay high.
- R6: H is `halfPeriod`, or 1 when `halfPeriod` is 0, sampled at acceptance. Counting from the first cycle after acceptance:
  - the select is low H cycles before `sclk` first falls;
  - every `sclk` phase lasts H cycles;
  - the last rising edge comes at cycle 32H;
  - the select rises at cycle 34H.
  A change of `halfPeriod` during a frame has no effect on that frame.
- R7: Out of reset and whenever the block is idle, `sclk`, `sdata` and both selects are high, and `busy` and `done` are low.
- R8: `busy` is high for exactly 34H cycles after an accepted request. A request made while `busy` is high is ignored and does not change the word or the timing.
- R9: `done` is high for exactly one cycle. That is the cycle in which the select returns high, and `busy` is already low in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Single-cycle write request |
| reqCodec | input | CODEC_W (2) | Target codec index |
| reqReg | input | ADDR_W (5) | Codec register index |
| reqData | input | DATA_W (8) | Data byte to write |
| halfPeriod | input | DIV_W (8) | Serial clock half period in system clock cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, idles high |
| csN | output | NUM_CODECS (2) | Active-low codec selects |

## Verification
The bound checker watches these properties on every cycle:
- at most one select is low, and a select does not move during a frame;
- the lines are idle-high whenever the block is not busy;
- data moves only while the clock is low;
- `done` is a single pulse that follows the select's rise;
- an accepted request leads to `busy`, and a rejected one does not.

Other properties need whole scenarios in the bench, because they depend on counting over a frame:
- the assembled word and its bit order;
- the exact phase lengths for a given divider, including the zero case;
- the 34H busy window;
- that a second request or a divider change in mid-frame has no effect.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } cwState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // accept request, drop select
    logic clkFall;  // drive clock low, present next bit
    logic clkRise;  // drive clock high
    logic finish;   // release select, return lines to idle
  } cwStrobe_t;

endpackage

// File: rtl/cw_ctrl.sv
module cw_ctrl
  import cw_pkg::*;
#(
  parameter int NUM_CODECS = 2,
  parameter int CODEC_W    = 2,
  parameter int DIV_W      = 8,
  parameter int FRAME_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CODEC_W-1:0] reqCodec,
  input  logic [DIV_W-1:0]   halfPeriod,
  output cwStrobe_t          strobe,
  output logic               busy
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  cwState_t         state;
  logic [DIV_W-1:0] hpReg;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] hpEff;
  logic             codecOk;
  logic             accept;
  logic             phaseEnd;

  assign codecOk  = int'(reqCodec) < NUM_CODECS;
  assign accept   = reqValid && (state == ST_IDLE) && codecOk;
  assign hpEff    = (halfPeriod == '0) ? ONE : halfPeriod;
  assign phaseEnd = (state != ST_IDLE) && (divCnt == '0);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    if (phaseEnd) begin
      unique case (state)
        ST_SETUP: strobe.clkFall = 1'b1;
        ST_LOW:   strobe.clkRise = 1'b1;
        ST_HIGH:  strobe.clkFall = (bitCnt != LAST_BIT);
        ST_HOLD:  strobe.finish  = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hpReg  <= ONE;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (accept) begin
      state  <= ST_SETUP;
      hpReg  <= hpEff;
      divCnt <= hpEff - ONE;
      bitCnt <= '0;
    end else if (phaseEnd) begin
      divCnt <= hpReg - ONE;
      unique case (state)
        ST_SETUP: state <= ST_LOW;
        ST_LOW:   state <= ST_HIGH;
        ST_HIGH: begin
          if (bitCnt == LAST_BIT) begin
            state <= ST_HOLD;
          end else begin
            state  <= ST_LOW;
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        ST_HOLD:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end else if (state != ST_IDLE) begin
      divCnt <= divCnt - ONE;
    end
  end

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_pkg::*;
#(
  parameter int               NUM_CODECS = 2,
  parameter int               CODEC_W    = 2,
  parameter int               ADDR_W     = 5,
  parameter int               DATA_W     = 8,
  parameter int               CHIP_ID_W  = 2,
  parameter logic [CHIP_ID_W-1:0] CHIP_ID = 2'b10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cwStrobe_t             strobe,
  input  logic [CODEC_W-1:0]    reqCodec,
  input  logic [ADDR_W-1:0]     reqReg,
  input  logic [DATA_W-1:0]     reqData,
  output logic                  sclk,
  output logic                  sdata,
  output logic [NUM_CODECS-1:0] csN,
  output logic                  done
);

  localparam int FRAME_W = CHIP_ID_W + 1 + ADDR_W + DATA_W;

  logic [FRAME_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      sclk  <= 1'b1;
      sdata <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        shReg <= {CHIP_ID, 1'b1, reqReg, reqData};
      end else if (strobe.clkFall) begin
        shReg <= {shReg[FRAME_W-2:0], 1'b0};
      end
      if (strobe.clkFall) begin
        sclk  <= 1'b0;
        sdata <= shReg[FRAME_W-1];
      end else if (strobe.clkRise) begin
        sclk <= 1'b1;
      end else if (strobe.finish) begin
        sclk  <= 1'b1;
        sdata <= 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < NUM_CODECS; gi++) begin : gSel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        csN[gi] <= 1'b1;
      end else if (strobe.finish) begin
        csN[gi] <= 1'b1;
      end else if (strobe.load) begin
        csN[gi] <= (int'(reqCodec) != gi);
      end
    end
  end

endmodule

// File: rtl/cw_writer.sv
module cw_writer
  import cw_pkg::*;
#(
  parameter int NUM_CODECS = 2,
  parameter int CODEC_W    = 2,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [CODEC_W-1:0]    reqCodec,
  input  logic [ADDR_W-1:0]     reqReg,
  input  logic [DATA_W-1:0]     reqData,
  input  logic [DIV_W-1:0]      halfPeriod,
  output logic                  busy,
  output logic                  done,
  output logic                  sclk,
  output logic                  sdata,
  output logic [NUM_CODECS-1:0] csN
);

  localparam int CHIP_ID_W = 2;
  localparam int FRAME_W   = CHIP_ID_W + 1 + ADDR_W + DATA_W;

  cwStrobe_t strobe;

  cw_ctrl #(
    .NUM_CODECS(NUM_CODECS),
    .CODEC_W   (CODEC_W),
    .DIV_W     (DIV_W),
    .FRAME_W   (FRAME_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCodec  (reqCodec),
    .halfPeriod(halfPeriod),
    .strobe    (strobe),
    .busy      (busy)
  );

  cw_datapath #(
    .NUM_CODECS(NUM_CODECS),
    .CODEC_W   (CODEC_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CHIP_ID_W (CHIP_ID_W),
    .CHIP_ID   (2'b10)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqCodec(reqCodec),
    .reqReg  (reqReg),
    .reqData (reqData),
    .sclk    (sclk),
    .sdata   (sdata),
    .csN     (csN),
    .done    (done)
  );

endmodule

// File: rtl/cw_writer_chk.sv
module cw_writer_chk #(
  parameter int NUM_CODECS = 2,
  parameter int CODEC_W    = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [CODEC_W-1:0]    reqCodec,
  input logic                  busy,
  input logic                  done,
  input logic                  sclk,
  input logic                  sdata,
  input logic [NUM_CODECS-1:0] csN
);

  logic codecOk;
  assign codecOk = int'(reqCodec) < NUM_CODECS;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R4

  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN)); // R4

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk && sdata && (&csN))); // R7

  AST_DATA_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdata) && !(&csN)) |-> !sclk); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((&csN) && !(&$past(csN)) && !busy)); // R9

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !codecOk) |=> !busy); // R5

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && codecOk) |=> busy); // R8

endmodule

bind cw_writer cw_writer_chk #(
  .NUM_CODECS(NUM_CODECS),
  .CODEC_W   (CODEC_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqCodec(reqCodec),
  .busy    (busy),
  .done    (done),
  .sclk    (sclk),
  .sdata   (sdata),
  .csN     (csN)
);

// File: tb/cw_writer_test.sv
module cw_writer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqCodec = '0;
  logic [4:0] reqReg = '0;
  logic [7:0] reqData = '0;
  logic [7:0] halfPeriod = 8'd1;
  logic       busy, done, sclk, sdata;
  logic [1:0] csN;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cw_writer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCodec(reqCodec),
    .reqReg(reqReg), .reqData(reqData), .halfPeriod(halfPeriod),
    .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .csN(csN)
  );

  function automatic logic [15:0] expWord(input logic [4:0] r, input logic [7:0] d);
    return {2'b10, 1'b1, r, d}; // R1 layout
  endfunction

  function automatic int effHalf(input int hp);
    return (hp == 0) ? 1 : hp;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  task automatic runFrame(input int codec, input logic [4:0] r, input logic [7:0] d,
                          input int hp, input bit inject);
    int h, k, busyCnt, rises, firstLow, lastRise, csRiseK, doneK, doneCnt;
    int badSel, badData;
    logic [15:0] word;
    logic prevSclk, prevSdata;
    logic [1:0] prevCs, expSel;
    h = effHalf(hp);
    expSel = (codec == 0) ? 2'b10 : 2'b01;
    busyCnt = 0; rises = 0; firstLow = -1; lastRise = -1; csRiseK = -1;
    doneK = -1; doneCnt = 0; badSel = 0; badData = 0; word = '0;
    @(negedge clk);
    reqValid = 1'b1; reqCodec = 2'(codec); reqReg = r; reqData = d;
    halfPeriod = 8'(hp);
    @(negedge clk);
    reqValid = 1'b0;
    prevSclk = 1'b1; prevSdata = 1'b1; prevCs = 2'b11;
    for (k = 0; k < 34*h + 4; k++) begin
      if (busy) busyCnt++;
      if (csN != 2'b11 && csN != expSel) badSel++;
      if (busy && csN != expSel) badSel++;
      if (sdata != prevSdata && csN != 2'b11 && sclk) badData++;
      if (!prevSclk && sclk) begin
        word = {word[14:0], sdata};
        rises++;
        lastRise = k;
      end
      if (prevSclk && !sclk && firstLow < 0) firstLow = k;
      if (csN == 2'b11 && prevCs != 2'b11) csRiseK = k;
      if (done) begin
        doneCnt++;
        doneK = k;
      end
      if (inject && k == 5) begin
        reqValid = 1'b1; reqCodec = 2'(1 - codec); reqData = ~d;
        halfPeriod = 8'(hp + 3);
      end
      if (inject && k == 6) reqValid = 1'b0;
      prevSclk = sclk; prevSdata = sdata; prevCs = csN;
      @(negedge clk);
    end
    check(word == expWord(r, d), "R1", "word", word, expWord(r, d));
    check(rises == 16, "R2", "rising edges", rises, 16);
    check(badData == 0, "R3", "data moved while clock high", badData, 0);
    check(badSel == 0, "R4", "select pattern errors", badSel, 0);
    check(firstLow == h, "R6", "select to first clock low", firstLow, h);
    check(lastRise == 32*h, "R6", "last rising edge", lastRise, 32*h);
    check(csRiseK == 34*h, "R6", "select release", csRiseK, 34*h);
    check(busyCnt == 34*h, "R8", "busy cycles", busyCnt, 34*h);
    check(doneCnt == 1 && doneK == 34*h, "R9", "done pulse cycle", doneK, 34*h);
    check(sclk && sdata && csN == 2'b11 && !busy, "R7", "idle after frame",
          {busy, sclk, sdata, csN}, 5'b01111);
  endtask

  task automatic runReject(input int codec);
    int moves;
    moves = 0;
    @(negedge clk);
    reqValid = 1'b1; reqCodec = 2'(codec); reqReg = 5'h1F; reqData = 8'h00;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (busy || done || !sclk || !sdata || csN != 2'b11) moves++;
      @(negedge clk);
    end
    check(moves == 0, "R5", "activity on rejected request", moves, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && sclk && sdata && csN == 2'b11, "R7",
          "reset state", {busy, done, sclk, sdata, csN}, 6'b001111);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && sclk && sdata && csN == 2'b11, "R7", "after reset release",
          {busy, sclk, sdata, csN}, 5'b01111);
    // directed corners
    runFrame(0, 5'h02, 8'hA5, 1, 1'b0);
    runFrame(1, 5'h1F, 8'hFF, 0, 1'b0);   // R6 zero divider treated as 1
    runFrame(1, 5'h00, 8'h00, 3, 1'b0);
    runFrame(0, 5'h15, 8'h3C, 2, 1'b1);   // R8 request while busy ignored
    runFrame(1, 5'h0A, 8'h81, 1, 1'b1);   // R8
    runReject(2);                         // R5
    runReject(3);                         // R5
    // random frames
    for (int i = 0; i < 8; i++) begin
      runFrame(int'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
               8'($urandom_range(0, 255)), int'($urandom_range(0, 5)), 1'b0);
    end
    summary();
    $finish;
  end

endmodule